// File: doc/BRIEF.md
# CPU Clock Source Switch Sequencer

This controller owns the two source-select fields of a CPU cluster clock tree and walks them through a frequency change. A requester offers a target CPU frequency in MHz on a valid/ready handshake. A legal request first moves the CPU clock onto the always-running alternate PLL. The controller then issues a one-cycle program strobe with the frequency the primary PLL must reach. It waits until the PLL reports lock on two consecutive cycles, then returns the CPU clock to the primary PLL along one of two routes:

- the direct output, which passes through the droop detector;
- the output halved through the secondary selector.

The primary PLL can only run between 600 MHz and 3000 MHz. Requests below 600 MHz therefore lock the PLL at twice the requested rate and take the halved route. Requests below 300 MHz or above 3000 MHz are refused with an error pulse. If lock does not arrive within a parameterised number of cycles, the controller raises the same error pulse and leaves the CPU clock parked on the alternate source.

A host can read both select fields as one 4-bit register and can write either field alone through per-field enables. The analog PLLs, the glitch-free clock muxes and the droop detector sit outside the block. They appear here only as select codes, the program strobe with its target value, and the lock input.

Top module: `cpu_clk_switch_seq`

## Requirements
- R1: After reset the primary select is 3 (alternate PLL), the secondary select is 0 (crystal), `req_ready` is 1 and `err_pulse` is 0.
- R2: `host_rdata` is {secondary select, primary select}, with the primary select in bits [1:0] and the secondary select in bits [3:2]. With `host_wr` high, `host_fen[0]` loads bits [1:0] into the primary select and `host_fen[1]` loads bits [3:2] into the secondary select. The field not enabled is left unchanged.
- R3: A host write is ignored while a request is in progress (`req_ready` low) and in any cycle where `req_valid` is high.
- R4: A request below MIN_MHZ (300) or above MAX_MHZ (3000) is refused. `err_pulse` is high for exactly the one cycle after the accepting edge, both selects keep their values, `req_ready` stays high and no program strobe is issued.
- R5: On the edge that accepts a legal request, the primary select becomes 3. `pll_prog` is high for exactly the following cycle, and the primary select is 3 during that cycle.
- R6: `pll_target_mhz` is twice the request when the request is below DIV_LIMIT_MHZ (600), and equal to the request otherwise.
- R7: The primary select leaves 3 only on a clock edge where `pll_lock` was sampled high both on that edge and on the edge before it, both while waiting for lock. A single-cycle lock pulse does not count.
- R8: For a request of 600 MHz or more, the primary select becomes 2 (droop-detected PLL output) on the second consecutive locked edge, and the secondary select is unchanged.
- R9: For a request below 600 MHz, the secondary select becomes 1 (PLL divided by two) on the second consecutive locked edge, and the primary select becomes 0 on the next edge.
- R10: If LOCK_TIMEOUT edges pass while waiting without a completed lock, `err_pulse` is raised for one cycle, the primary select stays 3 and the controller returns to ready.
- R11: `req_ready` is low from the accepting edge until the edge that writes the final select, and high again from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Frequency request offered |
| req_mhz | input | FREQ_W | Requested CPU frequency in MHz |
| req_ready | output | 1 | Controller idle and able to accept |
| pll_prog | output | 1 | One-cycle strobe to reprogram the primary PLL |
| pll_target_mhz | output | FREQ_W | Frequency the primary PLL must lock to |
| pll_lock | input | 1 | Primary PLL lock indication |
| sel_pri | output | 2 | Primary select: 0 halved path, 1 early PLL, 2 droop-detected PLL, 3 alternate PLL |
| sel_sec | output | 2 | Secondary select: 0 crystal, 1 PLL divided by two |
| host_wr | input | 1 | Host register write |
| host_fen | input | 2 | Field enables: bit 0 primary, bit 1 secondary |
| host_wdata | input | 4 | Host write data, same layout as host_rdata |
| host_rdata | output | 4 | Select register read value |
| err_pulse | output | 1 | One-cycle pulse on refused request or lock timeout |

## Verification
The bench builds the controller with FREQ_W at 12 and LOCK_TIMEOUT at 8. With a timeout of only eight cycles, the lock-timeout path can be reached and checked cycle by cycle against its exact expiry edge. The 12-bit request width can encode values beyond 3000, so the upper refusal bound is exercised as well as the lower one and the 599/600 split. A lock pulse lasting a single cycle is applied to show that it does not release the alternate source.

// File: rtl/cpu_clk_switch_seq.sv
module cpu_clk_switch_seq #(
  parameter int FREQ_W        = 12,
  parameter int MIN_MHZ       = 300,
  parameter int DIV_LIMIT_MHZ = 600,
  parameter int MAX_MHZ       = 3000,
  parameter int LOCK_TIMEOUT  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_mhz,
  output logic              req_ready,
  output logic              pll_prog,
  output logic [FREQ_W-1:0] pll_target_mhz,
  input  logic              pll_lock,
  output logic [1:0]        sel_pri,
  output logic [1:0]        sel_sec,
  input  logic              host_wr,
  input  logic [1:0]        host_fen,
  input  logic [3:0]        host_wdata,
  output logic [3:0]        host_rdata,
  output logic              err_pulse
);
  localparam int TO_W = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [FREQ_W-1:0] LO_F  = FREQ_W'(MIN_MHZ);
  localparam logic [FREQ_W-1:0] DIV_F = FREQ_W'(DIV_LIMIT_MHZ);
  localparam logic [FREQ_W-1:0] HI_F  = FREQ_W'(MAX_MHZ);
  localparam logic [TO_W-1:0]   TO_LAST = TO_W'(LOCK_TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_WAIT, S_SEC} state_t;

  state_t          state;
  logic            use_div;
  logic            lock_run;
  logic [TO_W-1:0] tmo;
  logic            illegal, low_rate;

  assign illegal    = (req_mhz < LO_F) || (req_mhz > HI_F);
  assign low_rate   = req_mhz < DIV_F;
  assign req_ready  = state == S_IDLE;
  assign pll_prog   = state == S_PROG;
  assign host_rdata = {sel_sec, sel_pri};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      sel_pri        <= 2'd3;
      sel_sec        <= 2'd0;
      pll_target_mhz <= '0;
      use_div        <= 1'b0;
      lock_run       <= 1'b0;
      tmo            <= '0;
      err_pulse      <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (illegal) begin
              err_pulse <= 1'b1;
            end else begin
              sel_pri        <= 2'd3;
              pll_target_mhz <= low_rate ? {req_mhz[FREQ_W-2:0], 1'b0} : req_mhz;
              use_div        <= low_rate;
              state          <= S_PROG;
            end
          end else if (host_wr) begin
            if (host_fen[0]) sel_pri <= host_wdata[1:0];
            if (host_fen[1]) sel_sec <= host_wdata[3:2];
          end
        end
        S_PROG: begin
          lock_run <= 1'b0;
          tmo      <= '0;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (pll_lock && lock_run) begin
            if (use_div) begin
              sel_sec <= 2'd1;
              state   <= S_SEC;
            end else begin
              sel_pri <= 2'd2;
              state   <= S_IDLE;
            end
          end else if (tmo == TO_LAST) begin
            err_pulse <= 1'b1;
            state     <= S_IDLE;
          end else begin
            tmo      <= tmo + 1'b1;
            lock_run <= pll_lock;
          end
        end
        S_SEC: begin
          sel_pri <= 2'd0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |-> (sel_pri == 2'd3) && !req_ready);

  p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |-> (pll_target_mhz >= DIV_F) && (pll_target_mhz <= HI_F));

  p_lock_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pri != 2'd3 && $past(sel_pri) == 2'd3 && $past(state) == S_WAIT)
      |-> ($past(pll_lock) && $past(pll_lock, 2)));

  p_sec_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pri == 2'd0 && $past(sel_pri) != 2'd0 && $past(state) == S_SEC)
      |-> (sel_sec == 2'd1));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && illegal)
      |=> err_pulse && $stable(sel_pri) && $stable(sel_sec) && req_ready);

  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(state) == S_WAIT) |-> (sel_pri == 2'd3) && req_ready);
endmodule

// File: tb/tb_cpu_clk_switch_seq.sv
module tb_cpu_clk_switch_seq;
  localparam int FW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, pll_lock = 1'b0, host_wr = 1'b0;
  logic [FW-1:0] req_mhz = '0;
  logic [1:0] host_fen = '0;
  logic [3:0] host_wdata = '0;
  logic req_ready, pll_prog, err_pulse;
  logic [FW-1:0] pll_target_mhz;
  logic [1:0] sel_pri, sel_sec;
  logic [3:0] host_rdata;

  int checks = 0, fails = 0;
  logic [1:0] exp_sec;

  always #10 clk = ~clk;

  cpu_clk_switch_seq #(.FREQ_W(FW), .LOCK_TIMEOUT(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mhz(req_mhz),
    .req_ready(req_ready), .pll_prog(pll_prog), .pll_target_mhz(pll_target_mhz),
    .pll_lock(pll_lock), .sel_pri(sel_pri), .sel_sec(sel_sec),
    .host_wr(host_wr), .host_fen(host_fen), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .err_pulse(err_pulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {mhz, legal, target}
  localparam logic [31:0] VEC [8] = '{
    {12'd300,  1'b1, 12'd600,  7'd0}, {12'd599,  1'b1, 12'd1198, 7'd0},
    {12'd600,  1'b1, 12'd600,  7'd0}, {12'd1500, 1'b1, 12'd1500, 7'd0},
    {12'd3000, 1'b1, 12'd3000, 7'd0}, {12'd299,  1'b0, 12'd0,    7'd0},
    {12'd3001, 1'b0, 12'd0,    7'd0}, {12'd0,    1'b0, 12'd0,    7'd0}};

  task automatic host_write(input logic [1:0] fen, input logic [3:0] d);
    host_wr = 1'b1; host_fen = fen; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_fen = '0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel_pri", sel_pri, 3);
    chk("R1 sel_sec", sel_sec, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 err", err_pulse, 0);

    host_write(2'b01, 4'b1101);
    chk("R2 primary field write", host_rdata, 4'h1);
    host_write(2'b10, 4'b1000);
    chk("R2 secondary field write", host_rdata, 4'h9);
    host_write(2'b11, 4'b0011);
    chk("R2 both fields", host_rdata, 4'h3);
    exp_sec = 2'd0;

    for (int i = 0; i < 8; i++) begin
      logic [11:0] mhz, tgt;
      logic ok, low;
      logic [1:0] pri0, sec0;
      mhz = VEC[i][31:20]; ok = VEC[i][19]; tgt = VEC[i][18:7];
      low = mhz < 12'd600;
      pri0 = sel_pri; sec0 = sel_sec;
      req_valid = 1'b1; req_mhz = mhz;
      @(negedge clk);
      req_valid = 1'b0;
      if (!ok) begin
        chk("R4 err pulse", err_pulse, 1);
        chk("R4 ready stays", req_ready, 1);
        chk("R4 selects untouched", {sel_sec, sel_pri}, {sec0, pri0});
        chk("R4 no prog", pll_prog, 0);
        @(negedge clk);
        chk("R4 err one cycle", err_pulse, 0);
        continue;
      end
      chk("R5 parked", sel_pri, 3);
      chk("R5 prog strobe", pll_prog, 1);
      chk("R11 ready low", req_ready, 0);
      chk("R6 target", pll_target_mhz, tgt);
      pll_lock = 1'b1;
      @(negedge clk);
      chk("R5 prog one cycle", pll_prog, 0);
      @(negedge clk);
      chk("R7 still alternate", sel_pri, 3);
      @(negedge clk);
      if (low) begin
        chk("R9 secondary first", sel_sec, 1);
        chk("R9 primary held", sel_pri, 3);
        chk("R11 ready low mid", req_ready, 0);
        @(negedge clk);
        chk("R9 primary halved", sel_pri, 0);
        exp_sec = 2'd1;
      end else begin
        chk("R8 primary direct", sel_pri, 2);
        chk("R8 secondary kept", sel_sec, exp_sec);
      end
      chk("R11 ready back", req_ready, 1);
      pll_lock = 1'b0;
      @(negedge clk);
    end

    // R7: single-cycle lock pulse is not enough
    req_valid = 1'b1; req_mhz = 12'd1000;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    pll_lock = 1'b1;
    @(negedge clk);
    pll_lock = 1'b0;
    @(negedge clk);
    chk("R7 glitch ignored", sel_pri, 3);
    host_write(2'b11, 4'b0000);
    chk("R3 write ignored busy", host_rdata, {exp_sec, 2'd3});
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R7 one high edge", sel_pri, 3);
    @(negedge clk);
    chk("R7 two high edges", sel_pri, 2);
    pll_lock = 1'b0;
    @(negedge clk);

    // R3: host write with a request present is ignored
    req_valid = 1'b1; req_mhz = 12'd100;
    host_wr = 1'b1; host_fen = 2'b11; host_wdata = 4'b0101;
    @(negedge clk);
    req_valid = 1'b0; host_wr = 1'b0;
    chk("R3 write ignored with request", host_rdata, {exp_sec, 2'd2});
    chk("R4 err low request", err_pulse, 1);
    @(negedge clk);

    // R10: lock timeout
    req_valid = 1'b1; req_mhz = 12'd800;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 no err before expiry", err_pulse, 0);
    @(negedge clk);
    chk("R10 err on expiry", err_pulse, 1);
    chk("R10 stays alternate", sel_pri, 3);
    chk("R10 ready back", req_ready, 1);
    @(negedge clk);
    chk("R10 err one cycle", err_pulse, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule